// File: doc/BRIEF.md
# SPI EEPROM Slave Command Front-End

This block is the serial front-end of a byte-organized EEPROM model. It watches an SPI bus as a slave, frames each transaction with an active-low chip select, and takes the first byte of every transaction as an opcode. It then collects a 16-bit address and data bytes, or returns memory or status bytes on a serial output that has a separate enable for a tri-state pad. The array, the write timing and the status register are outside this block. The front-end hands them single-cycle request strobes and a read address, and takes back read data and a status byte.

All pins are brought into a system clock domain through a two-stage synchronizer, and SCK edges are found in that domain. The system clock must therefore run several times faster than SCK. The same logic serves both the idle-low and the idle-high SCK conventions. A pause input freezes the bit sequence in place while SCK is low. An opcode the block does not recognise shuts it off until chip select is deasserted and asserted again.

Top module: `spi_eeprom_frontend`

## Requirements
- R1: Bits are received MSB first, and the first byte after chip select goes low is the opcode. 0x06 and 0x04 each produce one request, with kind 0 and kind 1 respectively. 0x01 takes the next byte and produces one request of kind 2 carrying that byte. Any later bytes in that transaction are ignored.
- R2: Opcode 0x02 is followed by a 16-bit address, sent high byte first. Only the low ADDR_W bits of the address reach the outputs. Each following data byte produces one request of kind 3, and the address rises by one for each byte.
- R3: Opcode 0x03 is followed by a 16-bit address. The block then returns rd_data for that address, MSB first, and goes on to successive addresses for as long as chip select stays low. The serial output changes only after SCK falling edges.
- R4: Opcode 0x05 returns the status input byte, MSB first, repeated for as long as chip select stays low.
- R5: Any other opcode produces no request and keeps the serial output disabled until chip select goes high and then low again. After that, a new transaction is decoded normally.
- R6: While chip select is high, SCK and SI have no effect and the serial output is disabled. Raising chip select in the middle of a byte discards the partial byte.
- R7: The pause input is sampled only while SCK is low. A low pulse on it that begins and ends while SCK stays high has no effect: the output stays enabled and the data is intact.
- R8: While paused, SCK edges do not advance the sequence, SI is ignored and the serial output is disabled. After release, the transaction continues from where it stopped.
- R9: Transactions work with SCK idling low and with SCK idling high. SI is sampled on SCK rising edges in both cases.
- R10: After reset, the output enable is low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low pause |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the SO pad |
| cmd_valid_o | output | 1 | One-cycle request strobe |
| cmd_kind_o | output | 2 | Request kind: 0 write enable, 1 write disable, 2 status write, 3 byte write |
| cmd_addr_o | output | ADDR_W | Byte address of a kind-3 request |
| cmd_data_o | output | 8 | Data byte of a kind-2 or kind-3 request |
| rd_req_o | output | 1 | Strobe: the read address changed |
| rd_addr_o | output | ADDR_W | Address of the next byte to return |
| rd_data_i | input | 8 | Array byte at rd_addr_o, valid before the next SCK falling edge |
| stat_i | input | 8 | Status byte returned by a status read |

## Verification
A wrong bit count or a missed clear shows up at the ports within one byte time. The next opcode is misaligned: either the request is lost or the block locks, or the read data comes back rotated. A pause that gates the wrong SCK level either lets the count move, which corrupts the address or data of the request that follows, or drops the output enable while SCK is high, which a sample taken during the pause shows at once. A lockout that leaks shows up as an extra request in the log or as a raised enable in the same transaction. A lockout that never clears shows up as a lost request in the next transaction.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int WIRE_AW   = 16;

  localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    CK_WEN = 2'd0, CK_WDIS = 2'd1, CK_STWR = 2'd2, CK_BYTE = 2'd3
  } cmd_kind_e;

  typedef enum logic [3:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_WDATA, ST_RDATA, ST_STAT, ST_STWR, ST_IGN, ST_LOCK
  } fe_state_e;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int            W       = 4,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_pins.sv
module spi_fe_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic cs_act_o,
  output logic hold_act_o,
  output logic sck_rise_o,
  output logic sck_fall_o
);
  logic sck_p, hold_q, hold_d, run;

  assign cs_act_o = !cs_n_s;

  always_comb begin
    hold_d = hold_q;
    if (!cs_act_o)   hold_d = 1'b0;
    else if (!sck_s) hold_d = !hold_n_s;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sck_p  <= sck_s;
      hold_q <= hold_d;
    end

  assign run        = cs_act_o && !hold_q;
  assign sck_rise_o = run &&  sck_s && !sck_p;
  assign sck_fall_o = run && !sck_s &&  sck_p;
  assign hold_act_o = hold_q;

  // R7: pause engages only from a cycle in which SCK was low
  p_hold_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> !$past(sck_s));
  // R7: pause releases only with SCK low, or because select dropped
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> (!$past(sck_s) || $past(cs_n_s)));
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
  import spi_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              si_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] rx_q, rx_d;

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    if (clr_i) begin
      cnt_d = '0;
      rx_d  = '0;
    end else if (rise_i) begin
      cnt_d = cnt_q + 1'b1;
      rx_d  = {rx_q[BYTE_W-3:0], si_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
    end

  assign cnt_o  = cnt_q;
  assign done_o = rise_i && !clr_i && (cnt_q == CNT_W'(BYTE_W-1));
  assign byte_o = {rx_q, si_i};
endmodule

// File: rtl/spi_eeprom_frontend.sv
module spi_eeprom_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_kind_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_data_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic [7:0]        stat_i
);
  logic [3:0] pins_s;
  logic sck_s, cs_n_s, si_s, hold_n_s;
  logic cs_act, hold_act, sck_rise, sck_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;

  spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sck_i, cs_n_i, si_i, hold_n_i}), .q_o(pins_s));
  assign {sck_s, cs_n_s, si_s, hold_n_s} = pins_s;

  spi_fe_pins u_pins (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .hold_n_s(hold_n_s),
    .cs_act_o(cs_act), .hold_act_o(hold_act), .sck_rise_o(sck_rise), .sck_fall_o(sck_fall));

  spi_fe_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(!cs_act), .rise_i(sck_rise), .si_i(si_s),
    .cnt_o(bit_cnt), .done_o(byte_done), .byte_o(byte_val));

  fe_state_e           state_q, state_d;
  logic [WIRE_AW-1:0]  addr_q, addr_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic                so_q, so_d, loaded_q, loaded_d, rd_op_q, rd_op_d;
  logic                cv_q, cv_d, rq_q, rq_d;
  cmd_kind_e           ck_q, ck_d;
  logic [ADDR_W-1:0]   ca_q, ca_d;
  logic [BYTE_W-1:0]   cd_q, cd_d;
  logic                out_state;

  assign out_state = (state_q == ST_RDATA) || (state_q == ST_STAT);

  always_comb begin
    state_d = state_q;  addr_d = addr_q;  tx_d = tx_q;  so_d = so_q;
    loaded_d = loaded_q;  rd_op_d = rd_op_q;
    cv_d = 1'b0;  rq_d = 1'b0;  ck_d = ck_q;  ca_d = ca_q;  cd_d = cd_q;
    if (!cs_act) begin
      state_d  = ST_OPC;
      loaded_d = 1'b0;
    end else begin
      if (byte_done) begin
        unique case (state_q)
          ST_OPC: begin
            unique case (byte_val)
              OP_WREN:  begin cv_d = 1'b1; ck_d = CK_WEN;  state_d = ST_IGN; end
              OP_WRDI:  begin cv_d = 1'b1; ck_d = CK_WDIS; state_d = ST_IGN; end
              OP_RDSR:  state_d = ST_STAT;
              OP_WRSR:  state_d = ST_STWR;
              OP_READ:  begin rd_op_d = 1'b1; state_d = ST_AHI; end
              OP_WRITE: begin rd_op_d = 1'b0; state_d = ST_AHI; end
              default:  state_d = ST_LOCK;
            endcase
          end
          ST_AHI: begin
            addr_d  = {byte_val, addr_q[BYTE_W-1:0]};
            state_d = ST_ALO;
          end
          ST_ALO: begin
            addr_d  = {addr_q[WIRE_AW-1:BYTE_W], byte_val};
            rq_d    = rd_op_q;
            state_d = rd_op_q ? ST_RDATA : ST_WDATA;
          end
          ST_WDATA: begin
            cv_d = 1'b1;  ck_d = CK_BYTE;  ca_d = addr_q[ADDR_W-1:0];  cd_d = byte_val;
            addr_d = addr_q + 1'b1;
          end
          ST_RDATA: begin
            addr_d = addr_q + 1'b1;
            rq_d   = 1'b1;
          end
          ST_STWR: begin
            cv_d = 1'b1;  ck_d = CK_STWR;  cd_d = byte_val;  state_d = ST_IGN;
          end
          default: ;
        endcase
      end
      if (sck_fall && out_state) begin
        if (bit_cnt == '0) begin
          tx_d     = (state_q == ST_RDATA) ? rd_data_i : stat_i;
          so_d     = tx_d[BYTE_W-1];
          loaded_d = 1'b1;
        end else begin
          so_d = tx_q[CNT_W'(BYTE_W-1) - bit_cnt];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= ST_OPC;  addr_q <= '0;  tx_q <= '0;  so_q <= 1'b0;
      loaded_q <= 1'b0;  rd_op_q <= 1'b0;  cv_q <= 1'b0;  rq_q <= 1'b0;
      ck_q <= CK_WEN;  ca_q <= '0;  cd_q <= '0;
    end else begin
      state_q <= state_d;  addr_q <= addr_d;  tx_q <= tx_d;  so_q <= so_d;
      loaded_q <= loaded_d;  rd_op_q <= rd_op_d;  cv_q <= cv_d;  rq_q <= rq_d;
      ck_q <= ck_d;  ca_q <= ca_d;  cd_q <= cd_d;
    end

  assign so_o        = so_q;
  assign so_oe_o     = cs_act && !hold_act && loaded_q && out_state;
  assign cmd_valid_o = cv_q;
  assign cmd_kind_o  = ck_q;
  assign cmd_addr_o  = ca_q;
  assign cmd_data_o  = cd_q;
  assign rd_req_o    = rq_q;
  assign rd_addr_o   = addr_q[ADDR_W-1:0];

  // R5: a locked transaction issues nothing in the following cycle
  p_lock_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK) |=> (!cmd_valid_o && !rd_req_o));
  // R5: output stays disabled while locked
  p_lock_no_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK) |-> !so_oe_o);
  // R6: deselect returns the framing to the opcode phase with an empty count
  p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (state_q == ST_OPC && bit_cnt == '0));
  // R8: bit count frozen while paused
  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && $past(hold_act) && cs_act && $past(cs_act)) |-> $stable(bit_cnt));
  // R3: serial output only moves after a falling SCK edge
  p_so_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe_o && $past(so_oe_o) && !$past(sck_fall)) |-> $stable(so_q));
endmodule

// File: tb/spi_eeprom_frontend_bench.sv
`timescale 1ns/1ps
module spi_eeprom_frontend_bench;
  localparam int AW = 13;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, cmd_valid, rd_req;
  logic [1:0] cmd_kind;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [7:0] cmd_data, rd_data, stat;

  always #10 clk = ~clk;

  assign rd_data = rd_addr[7:0] ^ 8'h5A;
  assign stat    = 8'hC3;

  spi_eeprom_frontend #(.ADDR_W(AW)) u_spi_eeprom_frontend (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si), .hold_n_i(hold_n),
    .so_o(so), .so_oe_o(so_oe), .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .rd_req_o(rd_req),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .stat_i(stat));

  logic [1:0]    lk [64];
  logic [AW-1:0] la [64];
  logic [7:0]    ld [64];
  int log_n = 0;

  always @(posedge clk)
    if (cmd_valid) begin
      lk[log_n[5:0]] <= cmd_kind;
      la[log_n[5:0]] <= cmd_addr;
      ld[log_n[5:0]] <= cmd_data;
      log_n <= log_n + 1;
    end

  int checks = 0, fails = 0;
  bit mode3 = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_start(input bit m3);
    mode3 = m3;
    sck = m3;
    tick(4);
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic frame_end();
    if (!mode3) sck = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  // kind 1: pause with SCK low, toggling SCK; kind 2: pulse pause with SCK high
  task automatic pause(input int kind, input bit exp_oe);
    if (kind == 1) begin
      sck = 1'b0; tick(HALF);
      hold_n = 1'b0; tick(HALF);
      for (int k = 0; k < 3; k++) begin
        sck = 1'b1; si = ~si; tick(4);
        sck = 1'b0; tick(4);
      end
      chk(so_oe == 1'b0, "R8 output disabled while paused", so_oe, 0);
      hold_n = 1'b1; tick(HALF);
    end else begin
      hold_n = 1'b0; tick(HALF);
      chk(so_oe == exp_oe, "R7 pause with SCK high ignored", so_oe, exp_oe);
      hold_n = 1'b1; tick(HALF);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, input int hold_at, input int hold_kind,
                       input bit hold_oe, output logic [7:0] rx, output bit oe_all,
                       output bit oe_any);
    oe_all = 1'b1; oe_any = 1'b0; rx = '0;
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) pause(hold_kind, hold_oe);
      sck = 1'b0; si = tx[i]; tick(HALF);
      rx[i] = so;
      oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1; tick(HALF);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; bit a, b;
    xbyte(tx, -1, 0, 1'b0, r, a, b);
  endtask

  task automatic t_reset();
    chk(so_oe == 1'b0, "R10 output enable after reset", so_oe, 0);
    chk(cmd_valid == 1'b0, "R10 no request after reset", cmd_valid, 0);
  endtask

  task automatic t_single(input logic [7:0] op, input bit m3, input int kind, input string req);
    int base = log_n;
    frame_start(m3); send(op); send(8'hFF); frame_end();
    chk(log_n == base + 1, req, log_n - base, 1);
    chk(lk[base[5:0]] == kind[1:0], req, lk[base[5:0]], kind);
  endtask

  task automatic t_write();
    int base = log_n; logic [7:0] r; bit a, any_oe = 1'b0, b;
    frame_start(1'b0);
    send(8'h02); send(8'hF2); send(8'h34);
    for (int i = 0; i < 3; i++) begin
      xbyte(8'h11 * (i + 1), -1, 0, 1'b0, r, a, b);
      any_oe |= b;
    end
    frame_end();
    chk(log_n == base + 3, "R2 three byte requests", log_n - base, 3);
    for (int i = 0; i < 3; i++) begin
      chk(lk[(base + i) % 64] == 2'd3, "R2 kind", lk[(base + i) % 64], 3);
      chk(la[(base + i) % 64] == AW'(16'h1234 + i), "R2 address, upper bits dropped",
          la[(base + i) % 64], 16'h1234 + i);
      chk(ld[(base + i) % 64] == 8'(8'h11 * (i + 1)), "R2 data", ld[(base + i) % 64], 8'h11 * (i + 1));
    end
    chk(any_oe == 1'b0, "R2 no output during write", any_oe, 0);
  endtask

  task automatic t_wrsr();
    int base = log_n;
    frame_start(1'b1); send(8'h01); send(8'h9C); send(8'h55); frame_end();
    chk(log_n == base + 1, "R1 R9 status write single request", log_n - base, 1);
    chk(lk[base[5:0]] == 2'd2, "R1 status write kind", lk[base[5:0]], 2);
    chk(ld[base[5:0]] == 8'h9C, "R1 status write data", ld[base[5:0]], 8'h9C);
  endtask

  task automatic t_read(input bit m3, input logic [15:0] a0, input int hold_at,
                        input int hold_kind, input string req);
    logic [7:0] r, e; bit oa, ob;
    frame_start(m3);
    send(8'h03); send(a0[15:8]); send(a0[7:0]);
    for (int i = 0; i < 3; i++) begin
      xbyte(8'h00, (i == 0) ? hold_at : -1, hold_kind, 1'b1, r, oa, ob);
      e = 8'(16'(a0 + i)) ^ 8'h5A;
      chk(r == e, req, r, e);
      chk(oa == 1'b1, {req, " output enabled"}, oa, 1);
    end
    frame_end();
    chk(so_oe == 1'b0, "R6 output off after deselect", so_oe, 0);
  endtask

  task automatic t_rdsr();
    logic [7:0] r; bit oa, ob;
    frame_start(1'b0); send(8'h05);
    for (int i = 0; i < 2; i++) begin
      xbyte(8'h00, -1, 0, 1'b0, r, oa, ob);
      chk(r == 8'hC3 && oa, "R4 status byte repeated", r, 8'hC3);
    end
    frame_end();
  endtask

  task automatic t_lock();
    int base = log_n; logic [7:0] r; bit oa, ob, any_oe = 1'b0;
    frame_start(1'b0);
    send(8'hA7);
    for (int i = 0; i < 4; i++) begin
      xbyte((i == 0) ? 8'h02 : 8'h06, -1, 0, 1'b0, r, oa, ob);
      any_oe |= ob;
    end
    frame_end();
    chk(log_n == base, "R5 no request after bad opcode", log_n - base, 0);
    chk(any_oe == 1'b0, "R5 output disabled after bad opcode", any_oe, 0);
    t_single(8'h06, 1'b0, 0, "R5 decode resumes after reselect");
  endtask

  task automatic t_deselect();
    int base = log_n; bit any_oe = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sck = 1'b0; si = i[0]; tick(HALF); any_oe |= so_oe;
      sck = 1'b1; tick(HALF);
    end
    sck = 1'b0; tick(HALF);
    chk(log_n == base, "R6 SCK ignored while deselected", log_n - base, 0);
    chk(any_oe == 1'b0, "R6 output off while deselected", any_oe, 0);
    frame_start(1'b0);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0; si = 1'b0; tick(HALF); sck = 1'b1; tick(HALF);
    end
    frame_end();
    t_single(8'h06, 1'b0, 0, "R6 partial byte discarded");
  endtask

  task automatic t_hold_write();
    int base = log_n; logic [7:0] r; bit a, b;
    frame_start(1'b0);
    send(8'h02); send(8'h00);
    xbyte(8'h40, 4, 1, 1'b0, r, a, b);
    send(8'h77);
    frame_end();
    chk(log_n == base + 1, "R8 pause mid-address keeps sequence", log_n - base, 1);
    chk(la[base[5:0]] == AW'(16'h0040), "R8 address after pause", la[base[5:0]], 16'h0040);
    chk(ld[base[5:0]] == 8'h77, "R8 data after pause", ld[base[5:0]], 8'h77);
  endtask

  task automatic run_all();
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_single(8'h06, 1'b0, 0, "R1 R9 write enable, idle low");
    t_single(8'h04, 1'b1, 1, "R1 R9 write disable, idle high");
    t_write();
    t_wrsr();
    t_read(1'b0, 16'h0100, -1, 0, "R3 R9 read data, idle low");
    t_read(1'b1, 16'hE0FF, -1, 0, "R3 R9 read data, idle high");
    t_rdsr();
    t_lock();
    t_deselect();
    t_hold_write();
    t_read(1'b0, 16'h0005, 4, 1, "R8 read data across pause");
    t_read(1'b1, 16'h0A10, 3, 2, "R7 read data across high-SCK pulse");
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timed_out = 1'b1; end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule